// File: doc/BRIEF.md
# Reconfigurable pin function mapper

This block sits between a chip's peripherals and three 8-pin general-purpose ports. Each of the 24 pins has a 5-bit selection register, written over a plain register bus. The stored code picks which peripheral function drives the pin's output value and output-enable, and which peripheral input receives the pin's value. The routing from the stored codes to the pins is purely combinational. A register write takes effect at the clock edge that accepts it.

Peripherals present their signals as vectors with one entry per function code: an output value (`fn_out`) and a direction request (`fn_oe`). They receive the pin values back on `fn_in`, which has the same indexing. Serial codes take their direction from the peripheral. The two open-drain codes only ever pull the pin low. Timer channel codes use the port's direction bit to choose between the capture input and the compare output. One code fans a pin out to the clock inputs of every timer. The top code switches a pin to analog use by turning off both its driver and its input buffer.

Top module: `pin_func_mapper`

## Requirements
- R1: After synchronous reset every pin register holds the default code, 0. Every read returns 0, every pin output is 0 and every input buffer is enabled.
- R2: A write to address a (pin index = port*8 + bit, a < 24) stores wr_data[4:0] and discards the upper bits, so 0xFF reads back as 31. The new code shows on rd_data and at the pins after the accepting edge. Writes to addresses 24 and above change nothing, and reads there return 0.
- R3: Code 0 and the unassigned code 30 drive pin_out low, let pin_oe follow pin_dir, keep the input buffer on, and feed no peripheral input.
- R4: Code 31 (analog) forces pin_oe and pin_ie to 0, and the pin feeds no peripheral input even when pin_in toggles.
- R5: Serial codes 1 to 24 (other than 20 and 22) give pin_out = fn_out[code] and pin_oe = fn_oe[code], independent of pin_dir, and feed the pin value to fn_in[code].
- R6: The open-drain codes 20 and 22 hold pin_out at 0 and set pin_oe = fn_oe[code] AND NOT fn_out[code]. The pin value feeds fn_in[code].
- R7: Timer channel codes 25 to 28 act as compare outputs when pin_dir is 1 (pin_out = fn_out[code], pin_oe = 1). When pin_dir is 0 they act as capture inputs (pin_oe = 0, pin value feeds fn_in[code]).
- R8: Code 29 is input only (pin_oe = 0). Its pin value drives all four bits of tmr_clk together.
- R9: Each fn_in bit is the OR of all pins mapped to that code. It is 0 when no pin is mapped, and fn_in[0], fn_in[30] and fn_in[31] are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Pin index for the write |
| wr_data | input | 8 | Write data; only bits 4:0 are kept |
| rd_addr | input | 5 | Pin index for readback |
| rd_data | output | 5 | Stored code at rd_addr |
| pin_dir | input | 24 | Port direction bits (1 = output) |
| pin_in | input | 24 | Pad input values |
| pin_out | output | 24 | Pad output values |
| pin_oe | output | 24 | Pad output enables |
| pin_ie | output | 24 | Pad input buffer enables |
| fn_out | input | 32 | Peripheral output value per function code |
| fn_oe | input | 32 | Peripheral direction request per function code |
| fn_in | output | 32 | Merged pin value per function code |
| tmr_clk | output | 4 | Clock input for each timer instance |

## Verification
On every cycle the assertions check four things. Writes must land in the addressed register, analog pins must keep both driver and buffer off, open-drain and unselected pins must never drive high, and the reserved function inputs and the timer clock fan-out must stay consistent. Only the bench scenarios can show the rest: the discarding of the upper write bits, ignored out-of-range addresses, the direction source per function class, the timer role swap with pin_dir, and OR merging when several pins share a code.

// File: rtl/pm_pkg.sv
package pm_pkg;
    localparam int CODE_W    = 5;
    localparam int NUM_CODES = 1 << CODE_W;
    localparam int BUS_W     = 8;

    localparam logic [CODE_W-1:0] C_NONE      = 5'd0;
    localparam logic [CODE_W-1:0] C_SER_LAST  = 5'd24;
    localparam logic [CODE_W-1:0] C_SDA       = 5'd20;
    localparam logic [CODE_W-1:0] C_SCL       = 5'd22;
    localparam logic [CODE_W-1:0] C_TMR_FIRST = 5'd25;
    localparam logic [CODE_W-1:0] C_TMR_LAST  = 5'd28;
    localparam logic [CODE_W-1:0] C_TCLK      = 5'd29;
    localparam logic [CODE_W-1:0] C_ANALOG    = 5'd31;

    typedef enum logic [2:0] {
        FC_NONE,
        FC_SERIAL,
        FC_ODRAIN,
        FC_TIMER,
        FC_TCLK,
        FC_ANALOG
    } fclass_e;

    typedef struct packed {
        logic out;
        logic oe;
        logic ie;
    } pad_ctl_t;

    function automatic fclass_e classify(input logic [CODE_W-1:0] c);
        if (c == C_ANALOG)                          return FC_ANALOG;
        else if (c == C_SDA || c == C_SCL)          return FC_ODRAIN;
        else if (c != C_NONE && c <= C_SER_LAST)    return FC_SERIAL;
        else if (c >= C_TMR_FIRST && c <= C_TMR_LAST) return FC_TIMER;
        else if (c == C_TCLK)                       return FC_TCLK;
        else                                        return FC_NONE;
    endfunction
endpackage

// File: rtl/pm_cfg_regs.sv
module pm_cfg_regs
    import pm_pkg::*;
#(
    parameter int                NPINS    = 24,
    parameter int                IDX_W    = 5,
    parameter logic [CODE_W-1:0] RST_CODE = '0
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           wr_en,
    input  logic [IDX_W-1:0]               wr_addr,
    input  logic [BUS_W-1:0]               wr_data,
    input  logic [IDX_W-1:0]               rd_addr,
    output logic [CODE_W-1:0]              rd_data,
    output logic [NPINS-1:0][CODE_W-1:0]   codes
);
    logic unused_hi;
    assign unused_hi = ^wr_data[BUS_W-1:CODE_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NPINS; i++) codes[i] <= RST_CODE;
        end else if (wr_en && int'(wr_addr) < NPINS) begin
            codes[wr_addr] <= wr_data[CODE_W-1:0];
        end
    end

    always_comb begin
        if (int'(rd_addr) < NPINS) rd_data = codes[rd_addr];
        else                       rd_data = '0;
    end
endmodule

// File: rtl/pm_pin_route.sv
module pm_pin_route
    import pm_pkg::*;
(
    input  logic [CODE_W-1:0]    code,
    input  logic [NUM_CODES-1:0] fn_out,
    input  logic [NUM_CODES-1:0] fn_oe,
    input  logic                 dir,
    input  logic                 pin_in,
    output pad_ctl_t             pad,
    output logic [NUM_CODES-1:0] feed
);
    fclass_e cls;
    logic    sel_out;
    logic    sel_oe;
    logic    take_in;

    always_comb begin
        cls     = classify(code);
        sel_out = fn_out[code];
        sel_oe  = fn_oe[code];
        pad     = '{out: 1'b0, oe: 1'b0, ie: 1'b1};
        take_in = 1'b0;
        unique case (cls)
            FC_NONE:   pad.oe = dir;
            FC_SERIAL: begin
                pad.out = sel_out;
                pad.oe  = sel_oe;
                take_in = 1'b1;
            end
            FC_ODRAIN: begin
                pad.oe  = sel_oe & ~sel_out;
                take_in = 1'b1;
            end
            FC_TIMER: begin
                if (dir) begin
                    pad.out = sel_out;
                    pad.oe  = 1'b1;
                end else begin
                    take_in = 1'b1;
                end
            end
            FC_TCLK:   take_in = 1'b1;
            FC_ANALOG: pad.ie = 1'b0;
            default:   pad.oe = dir;
        endcase
        feed       = '0;
        feed[code] = take_in & pin_in & pad.ie;
    end
endmodule

// File: rtl/pm_input_merge.sv
module pm_input_merge
    import pm_pkg::*;
#(
    parameter int NPINS = 24,
    parameter int NTMR  = 4
) (
    input  logic [NPINS-1:0][NUM_CODES-1:0] feeds,
    output logic [NUM_CODES-1:0]            fn_in,
    output logic [NTMR-1:0]                 tmr_clk
);
    always_comb begin
        fn_in = '0;
        for (int p = 0; p < NPINS; p++) fn_in = fn_in | feeds[p];
        tmr_clk = {NTMR{fn_in[C_TCLK]}};
    end
endmodule

// File: rtl/pin_func_mapper.sv
module pin_func_mapper
    import pm_pkg::*;
#(
    parameter int                NUM_PORTS  = 3,
    parameter int                PORT_W     = 8,
    parameter int                NUM_TIMERS = 4,
    parameter logic [CODE_W-1:0] RST_CODE   = '0,
    localparam int               NPINS      = NUM_PORTS * PORT_W,
    localparam int               IDX_W      = $clog2(NPINS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_addr,
    input  logic [BUS_W-1:0]     wr_data,
    input  logic [IDX_W-1:0]     rd_addr,
    output logic [CODE_W-1:0]    rd_data,
    input  logic [NPINS-1:0]     pin_dir,
    input  logic [NPINS-1:0]     pin_in,
    output logic [NPINS-1:0]     pin_out,
    output logic [NPINS-1:0]     pin_oe,
    output logic [NPINS-1:0]     pin_ie,
    input  logic [NUM_CODES-1:0] fn_out,
    input  logic [NUM_CODES-1:0] fn_oe,
    output logic [NUM_CODES-1:0] fn_in,
    output logic [NUM_TIMERS-1:0] tmr_clk
);
    logic [NPINS-1:0][CODE_W-1:0]    codes;
    logic [NPINS-1:0][NUM_CODES-1:0] feeds;

    pm_cfg_regs #(.NPINS(NPINS), .IDX_W(IDX_W), .RST_CODE(RST_CODE)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .codes(codes)
    );

    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        pad_ctl_t pad;
        pm_pin_route u_route (
            .code(codes[g]), .fn_out(fn_out), .fn_oe(fn_oe),
            .dir(pin_dir[g]), .pin_in(pin_in[g]), .pad(pad), .feed(feeds[g])
        );
        assign pin_out[g] = pad.out;
        assign pin_oe[g]  = pad.oe;
        assign pin_ie[g]  = pad.ie;
    end

    pm_input_merge #(.NPINS(NPINS), .NTMR(NUM_TIMERS)) u_merge (
        .feeds(feeds), .fn_in(fn_in), .tmr_clk(tmr_clk)
    );
endmodule

// File: rtl/pm_checker.sv
module pm_checker
    import pm_pkg::*;
#(
    parameter int NPINS = 24,
    parameter int IDX_W = 5,
    parameter int NTMR  = 4
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         wr_en,
    input logic [IDX_W-1:0]             wr_addr,
    input logic [BUS_W-1:0]             wr_data,
    input logic [NPINS-1:0][CODE_W-1:0] codes,
    input logic [NPINS-1:0]             pin_out,
    input logic [NPINS-1:0]             pin_oe,
    input logic [NPINS-1:0]             pin_ie,
    input logic [NUM_CODES-1:0]         fn_in,
    input logic [NTMR-1:0]              tmr_clk
);
    a_r2_write_lands: assert property (@(posedge clk) disable iff (rst)
        (wr_en && int'(wr_addr) < NPINS) |=>
            codes[$past(wr_addr)] == $past(wr_data[CODE_W-1:0]));

    a_r8_tclk_fanout: assert property (@(posedge clk) disable iff (rst)
        ($countones(tmr_clk) == 0 || $countones(tmr_clk) == NTMR));

    a_r9_reserved_quiet: assert property (@(posedge clk) disable iff (rst)
        !fn_in[C_NONE] && !fn_in[C_ANALOG]);

    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        a_r4_analog_off: assert property (@(posedge clk) disable iff (rst)
            codes[g] == C_ANALOG |-> (!pin_oe[g] && !pin_ie[g]));
        a_r6_odrain_low: assert property (@(posedge clk) disable iff (rst)
            (codes[g] == C_SDA || codes[g] == C_SCL) |-> !pin_out[g]);
        a_r3_none_low: assert property (@(posedge clk) disable iff (rst)
            codes[g] == C_NONE |-> (!pin_out[g] && pin_ie[g]));
    end
endmodule

bind pin_func_mapper pm_checker #(.NPINS(NPINS), .IDX_W(IDX_W), .NTMR(NUM_TIMERS)) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .codes(codes), .pin_out(pin_out), .pin_oe(pin_oe), .pin_ie(pin_ie),
    .fn_in(fn_in), .tmr_clk(tmr_clk)
);

// File: tb/tb_pin_func_mapper.sv
module tb_pin_func_mapper;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [4:0]  wr_addr;
    logic [7:0]  wr_data;
    logic [4:0]  rd_addr;
    logic [4:0]  rd_data;
    logic [23:0] pin_dir, pin_in, pin_out, pin_oe, pin_ie;
    logic [31:0] fn_out, fn_oe, fn_in;
    logic [3:0]  tmr_clk;

    pin_func_mapper dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .pin_dir(pin_dir), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .pin_ie(pin_ie), .fn_out(fn_out),
        .fn_oe(fn_oe), .fn_in(fn_in), .tmr_clk(tmr_clk)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    localparam int S_OUT = 0, S_OE = 1, S_IE = 2, S_FNIN = 3, S_RD = 4, S_TCLK = 5;

    typedef struct {
        int          sel;
        logic [31:0] mask;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    event  chk_ev;
    int    n_chk = 0;
    int    n_err = 0;
    bit    done  = 0;

    function automatic logic [31:0] pick(int sel);
        case (sel)
            S_OUT:  return {8'h0, pin_out};
            S_OE:   return {8'h0, pin_oe};
            S_IE:   return {8'h0, pin_ie};
            S_FNIN: return fn_in;
            S_RD:   return {27'h0, rd_data};
            default: return {28'h0, tmr_clk};
        endcase
    endfunction

    // monitor: pops expected items and compares them with the outputs
    initial begin
        forever begin
            @(chk_ev);
            while (q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it  = q.pop_front();
                act = pick(it.sel);
                n_chk++;
                if ((act & it.mask) != (it.exp & it.mask)) begin
                    n_err++;
                    $display("FAIL %s: actual=%h expected=%h (mask %h)",
                             it.tag, act & it.mask, it.exp & it.mask, it.mask);
                end
            end
        end
    end

    task automatic expect_v(int sel, logic [31:0] mask, logic [31:0] exp, string tag);
        q.push_back('{sel: sel, mask: mask, exp: exp, tag: tag});
    endtask

    task automatic flush();
        #1;
        ->chk_ev;
        #1;
    endtask

    task automatic wr(int a, logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 5'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(int a, logic [4:0] exp, string tag);
        rd_addr = 5'(a);
        #1;
        expect_v(S_RD, 32'h1F, {27'h0, exp}, tag);
        flush();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
        pin_dir = '0; pin_in = '0; fn_out = '0; fn_oe = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd_chk(0,  5'd0, "R1 reset readback pin0");
        rd_chk(23, 5'd0, "R1 reset readback pin23");
        expect_v(S_OUT, 32'hFFFFFF, 32'h0, "R1 reset pin_out");
        expect_v(S_OE,  32'hFFFFFF, 32'h0, "R1 reset pin_oe");
        expect_v(S_IE,  32'hFFFFFF, 32'hFFFFFF, "R1 reset pin_ie");
        flush();

        // R3 code 0: oe follows port direction
        pin_dir = 24'hFFFFFF;
        flush();
        expect_v(S_OE, 32'hFFFFFF, 32'hFFFFFF, "R3 code0 oe follows dir");
        flush();
        pin_dir = '0;

        // R2 upper bits dropped, R4 analog
        wr(5, 8'hFF);
        rd_chk(5, 5'd31, "R2 0xFF reads 31");
        pin_dir = 24'h000020; pin_in = 24'h000020;
        flush();
        expect_v(S_OE, 32'h20, 32'h0, "R4 analog oe off");
        expect_v(S_IE, 32'h20, 32'h0, "R4 analog ie off");
        expect_v(S_FNIN, 32'hFFFFFFFF, 32'h0, "R4 analog feeds nothing");
        flush();
        pin_dir = '0; pin_in = '0;

        // R2 out-of-range write ignored, partial bits kept
        wr(30, 8'h03);
        rd_chk(30, 5'd0, "R2 out-of-range read 0");
        rd_chk(0,  5'd0, "R2 out-of-range write ignored");
        wr(6, 8'hE3);
        rd_chk(6, 5'd3, "R2 upper bits dropped");

        // R5 serial output, direction from peripheral
        fn_out[3] = 1'b1; fn_oe[3] = 1'b1;
        flush();
        expect_v(S_OUT, 32'h40, 32'h40, "R5 serial out");
        expect_v(S_OE,  32'h40, 32'h40, "R5 serial oe from peripheral");
        flush();
        fn_oe[3] = 1'b0; pin_dir = 24'h000040;
        flush();
        expect_v(S_OE, 32'h40, 32'h0, "R5 serial oe ignores pin_dir");
        flush();
        pin_dir = '0;

        // R5 serial input
        wr(1, 8'd1);
        pin_in = 24'h000002;
        flush();
        expect_v(S_FNIN, 32'h2, 32'h2, "R5 serial input feed");
        flush();
        pin_in = '0;
        flush();
        expect_v(S_FNIN, 32'h2, 32'h0, "R5 serial input low");
        flush();

        // R6 open drain, R9 merge
        wr(8, 8'd20);
        wr(9, 8'd20);
        fn_oe[20] = 1'b1; fn_out[20] = 1'b0;
        flush();
        expect_v(S_OE,  32'h300, 32'h300, "R6 odrain drive low oe");
        expect_v(S_OUT, 32'h300, 32'h0,   "R6 odrain out low");
        flush();
        fn_out[20] = 1'b1;
        flush();
        expect_v(S_OE,  32'h300, 32'h0, "R6 odrain release");
        expect_v(S_OUT, 32'h300, 32'h0, "R6 odrain never high");
        flush();
        pin_in = 24'h000100;
        flush();
        expect_v(S_FNIN, 32'h100000, 32'h100000, "R9 OR pin8");
        flush();
        pin_in = 24'h000200;
        flush();
        expect_v(S_FNIN, 32'h100000, 32'h100000, "R9 OR pin9");
        flush();
        pin_in = '0;
        flush();
        expect_v(S_FNIN, 32'h100000, 32'h0, "R9 OR none high");
        expect_v(S_FNIN, 32'h00800000, 32'h0, "R9 unmapped code 23 reads 0");
        flush();

        // R7 timer role swap
        wr(16, 8'd25);
        pin_dir = 24'h010000; fn_out[25] = 1'b1; pin_in = 24'h010000;
        flush();
        expect_v(S_OUT,  32'h10000, 32'h10000, "R7 compare out");
        expect_v(S_OE,   32'h10000, 32'h10000, "R7 compare oe");
        expect_v(S_FNIN, 32'h2000000, 32'h0, "R7 no capture when output");
        flush();
        pin_dir = '0;
        flush();
        expect_v(S_OE,   32'h10000, 32'h0, "R7 capture oe off");
        expect_v(S_FNIN, 32'h2000000, 32'h2000000, "R7 capture feed");
        flush();
        pin_in = '0;

        // R8 timer clock fan-out
        wr(23, 8'd29);
        pin_dir = 24'h800000; pin_in = 24'h800000;
        flush();
        expect_v(S_TCLK, 32'hF, 32'hF, "R8 tclk all high");
        expect_v(S_OE, 32'h800000, 32'h0, "R8 tclk input only");
        flush();
        pin_in = '0;
        flush();
        expect_v(S_TCLK, 32'hF, 32'h0, "R8 tclk all low");
        flush();
        pin_dir = '0;

        // R3 unassigned code 30 acts like code 0
        wr(4, 8'd30);
        fn_out = 32'hFFFFFFFF; pin_in = 24'h000010;
        flush();
        expect_v(S_OUT,  32'h10, 32'h0, "R3 code30 out low");
        expect_v(S_FNIN, 32'h40000000, 32'h0, "R3 code30 feeds nothing");
        flush();
        fn_out = '0; pin_in = '0;

        // R4 leaving analog re-enables input buffer
        wr(5, 8'd0);
        expect_v(S_IE, 32'h20, 32'h20, "R4 buffer back on after analog");
        flush();

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule